// File: doc/BRIEF.md
# Key Combination Detector Channel

This block is one channel of a button-combination detector. It watches a small set of active-low key lines, which have already been inverted as configured. One programmable subset of the keys forms a trigger. When every key in that subset is pressed, and stays pressed long enough, the channel raises single-cycle pulses. Each pulse requests one downstream action: battery cut-off, an interrupt, an external-controller reset pulse, or a system reset. The units that latch or stretch those requests sit outside this block.

An optional second subset of keys acts as a gate. While the gate mask is nonzero, the gate keys must be held down for their own programmed time before the channel starts looking for the trigger. Both checks use a cheap two-sample debounce: the line is sampled when the debounce timer starts and again when it expires. After that comes a hold phase, in which the line must stay low on every cycle. A sticky status bit records each detection until it is cleared.

Top module: `kcd_combo_channel`

## Requirements
- R1: Key bit i is 0 when key i is pressed. The combined trigger is low only when every key selected by a 1 in `trig_sel_i` is pressed. If any selected key is released, no detection can start or complete.
- R2: Debounce takes two samples only. The first is at the clock edge that starts a phase; the second is `deb_i` edges later, and a `deb_i` of 0 counts as 1. Changes of the line between the two samples are ignored.
- R3: A combo phase starts at a clock edge where the combined trigger is low and was high at the previous edge. A detection needs the trigger low at that edge, at the second debounce sample and at each of the following `combo_hold_i` edges (0 counts as 1). When the trigger is low for `deb+hold+1` consecutive edges, the channel fires. One edge fewer does not fire.
- R4: If the trigger rises during the hold phase, the attempt is dropped. A fresh falling edge is then needed.
- R5: With a nonzero `pre_sel_i`, the combined gate keys must be low for `deb+pre_hold+1` consecutive edges before a trigger falling edge is accepted. The gate is checked on level. A trigger that is already low when the gate opens does not fire.
- R6: Releasing any gate key aborts a combo attempt in progress, with no action.
- R7: With `pre_sel_i` all zero, combo edge detection is armed directly.
- R8: A detection produces exactly one pulse, one cycle wide, on each action output whose `act_en_i` bit is set. The bits map as 0 = battery cut-off, 1 = interrupt, 2 = controller reset, 3 = system reset. Outputs whose bit is clear stay low.
- R9: `stat_o` goes high in the cycle after the action pulse. It stays high until `stat_clr_i` is sampled high, and a detection in the same cycle as a clear wins.
- R10: While `en_i` is low, no pulse is produced, and all phases return to idle at the next edge. After re-enabling, a new trigger falling edge is required.
- R11: While reset is asserted, and directly after it, all action outputs and `stat_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| keys_n_i | input | NKEYS | Key lines, 0 = pressed |
| trig_sel_i | input | NKEYS | Keys forming the combo trigger |
| pre_sel_i | input | NKEYS | Keys forming the gate; zero disables the gate |
| deb_i | input | TW | Debounce time in cycles |
| pre_hold_i | input | TW | Gate hold time in cycles |
| combo_hold_i | input | TW | Combo hold time in cycles |
| act_en_i | input | 4 | Action enables |
| stat_clr_i | input | 1 | Clears the sticky status |
| bat_off_o | output | 1 | Battery cut-off request pulse |
| irq_o | output | 1 | Interrupt request pulse |
| ec_rst_o | output | 1 | Controller reset request pulse |
| sys_rst_o | output | 1 | System reset request pulse |
| stat_o | output | 1 | Sticky detection status |

## Verification
The table-driven part holds the trigger low for exactly `deb+hold+1` edges and for one edge fewer, which separates an off-by-one in the hold count from a correct one. It also presses only part of the selected keys, which exposes a wrong key-combining polarity. Gate cases open the trigger one edge before and exactly at the point where the gate is satisfied, and zero timer values check the clamp. Directed runs cover a bounce inside the debounce window, which must be ignored, and a rise inside the hold phase, which must abort. They also cover releasing the gate mid-attempt and dropping the enable, each of which must cancel the attempt and demand a new falling edge.

// File: rtl/kcd_pkg.sv
package kcd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DEB  = 2'd1,
      ST_HOLD = 2'd2,
      ST_DONE = 2'd3
   } kcd_state_e;

   localparam int NUM_ACT = 4;
   localparam int ACT_BAT = 0;
   localparam int ACT_IRQ = 1;
   localparam int ACT_EC  = 2;
   localparam int ACT_SYS = 3;
endpackage

// File: rtl/kcd_key_merge.sv
module kcd_key_merge #(
   parameter int NKEYS = 4
) (
   input  logic [NKEYS-1:0] keys_n_i,
   input  logic [NKEYS-1:0] sel_i,
   output logic             merged_n_o
);
   logic [NKEYS-1:0] masked;

   generate
      for (genvar i = 0; i < NKEYS; i++) begin : g_key
         assign masked[i] = keys_n_i[i] & sel_i[i];
      end
   endgenerate

   // any selected key released keeps the combined line high
   assign merged_n_o = |masked;
endmodule

// File: rtl/kcd_stage.sv
module kcd_stage
   import kcd_pkg::*;
#(
   parameter int TW        = 16,
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic          sig_i,
   input  logic [TW-1:0] deb_i,
   input  logic [TW-1:0] hold_i,
   output logic          done_o
);
   kcd_state_e    state_q;
   logic [TW-1:0] cnt_q;
   logic          prev_q;
   logic          fire_q;
   logic          start;
   logic [TW-1:0] deb_lim;
   logic [TW-1:0] hold_lim;

   assign deb_lim  = (deb_i  == '0) ? TW'(1) : deb_i;
   assign hold_lim = (hold_i == '0) ? TW'(1) : hold_i;

   generate
      if (EDGE_MODE) begin : g_edge
         assign start  = prev_q & ~sig_i;
         assign done_o = fire_q;
      end else begin : g_level
         assign start  = ~sig_i;
         assign done_o = (state_q == ST_DONE) & ~fire_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         prev_q  <= 1'b1;
         fire_q  <= 1'b0;
      end else begin
         prev_q <= sig_i;
         fire_q <= 1'b0;
         if (!en_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (start) begin
                     state_q <= ST_DEB;
                     cnt_q   <= TW'(1);
                  end
               end
               ST_DEB: begin
                  if (cnt_q >= deb_lim) begin
                     cnt_q   <= TW'(1);
                     state_q <= sig_i ? ST_IDLE : ST_HOLD;
                  end else begin
                     cnt_q <= cnt_q + TW'(1);
                  end
               end
               ST_HOLD: begin
                  if (sig_i) begin
                     state_q <= ST_IDLE;
                     cnt_q   <= '0;
                  end else if (cnt_q >= hold_lim) begin
                     state_q <= ST_DONE;
                     fire_q  <= EDGE_MODE;
                  end else begin
                     cnt_q <= cnt_q + TW'(1);
                  end
               end
               ST_DONE: begin
                  if (sig_i) begin
                     state_q <= ST_IDLE;
                     cnt_q   <= '0;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assert_fire_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_q |-> !$past(sig_i));

   assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_q |=> !fire_q);

   assert_idle_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (state_q == ST_IDLE && !fire_q));

   assert_level_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!EDGE_MODE && en_i && state_q == ST_DONE && sig_i) |=> !done_o);
endmodule

// File: rtl/kcd_combo_channel.sv
module kcd_combo_channel
   import kcd_pkg::*;
#(
   parameter int NKEYS = 4,
   parameter int TW    = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [NKEYS-1:0] keys_n_i,
   input  logic [NKEYS-1:0] trig_sel_i,
   input  logic [NKEYS-1:0] pre_sel_i,
   input  logic [TW-1:0]    deb_i,
   input  logic [TW-1:0]    pre_hold_i,
   input  logic [TW-1:0]    combo_hold_i,
   input  logic [3:0]       act_en_i,
   input  logic             stat_clr_i,
   output logic             bat_off_o,
   output logic             irq_o,
   output logic             ec_rst_o,
   output logic             sys_rst_o,
   output logic             stat_o
);
   initial begin
      assert (NKEYS >= 1 && NKEYS <= 32) else $error("NKEYS out of range");
      assert (TW >= 2) else $error("TW too small");
   end

   logic trig_n, pre_n;
   logic pre_used, pre_ok, armed, hit;
   logic stat_q;
   logic [NUM_ACT-1:0] act_vec;

   kcd_key_merge #(.NKEYS(NKEYS)) i_trig_merge (
      .keys_n_i (keys_n_i),
      .sel_i    (trig_sel_i),
      .merged_n_o(trig_n)
   );

   kcd_key_merge #(.NKEYS(NKEYS)) i_pre_merge (
      .keys_n_i (keys_n_i),
      .sel_i    (pre_sel_i),
      .merged_n_o(pre_n)
   );

   assign pre_used = |pre_sel_i;

   kcd_stage #(.TW(TW), .EDGE_MODE(1'b0)) i_pre_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i & pre_used),
      .sig_i  (pre_n),
      .deb_i  (deb_i),
      .hold_i (pre_hold_i),
      .done_o (pre_ok)
   );

   // gate opens when the level stage is done and the gate keys are still down
   assign armed = en_i & (~pre_used | (pre_ok & ~pre_n));

   kcd_stage #(.TW(TW), .EDGE_MODE(1'b1)) i_combo_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (armed),
      .sig_i  (trig_n),
      .deb_i  (deb_i),
      .hold_i (combo_hold_i),
      .done_o (hit)
   );

   assign act_vec   = {NUM_ACT{hit}} & act_en_i;
   assign bat_off_o = act_vec[ACT_BAT];
   assign irq_o     = act_vec[ACT_IRQ];
   assign ec_rst_o  = act_vec[ACT_EC];
   assign sys_rst_o = act_vec[ACT_SYS];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         stat_q <= 1'b0;
      else if (hit)        stat_q <= 1'b1;
      else if (stat_clr_i) stat_q <= 1'b0;
   end
   assign stat_o = stat_q;

   assert_status_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o && !stat_clr_i) |=> stat_o);

   assert_status_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> stat_o);

   assert_armed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && pre_used) |-> $past(pre_ok));

   assert_action_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o || bat_off_o || ec_rst_o || sys_rst_o) |-> hit);
endmodule

// File: tb/test_kcd_combo_channel.sv
module test_kcd_combo_channel;
   localparam int NK = 4;
   localparam int TW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [NK-1:0] keys = '1;
   logic [NK-1:0] tsel = '0, psel = '0;
   logic [TW-1:0] deb = '0, ph = '0, ch = '0;
   logic [3:0] act = '0;
   logic clr = 1'b0;
   logic bat, irq, ec, sys, stat;

   int errors = 0;
   int checks = 0;
   int n_bat = 0, n_irq = 0, n_ec = 0, n_sys = 0;

   always #2 clk = ~clk;

   kcd_combo_channel #(.NKEYS(NK), .TW(TW)) i_kcd_combo_channel (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .keys_n_i(keys),
      .trig_sel_i(tsel), .pre_sel_i(psel), .deb_i(deb), .pre_hold_i(ph),
      .combo_hold_i(ch), .act_en_i(act), .stat_clr_i(clr),
      .bat_off_o(bat), .irq_o(irq), .ec_rst_o(ec), .sys_rst_o(sys), .stat_o(stat)
   );

   always @(posedge clk) begin
      if (bat) n_bat++;
      if (irq) n_irq++;
      if (ec)  n_ec++;
      if (sys) n_sys++;
   end

   typedef struct packed {
      logic [3:0] t, p, q;
      logic [7:0] d, h, c;
      logic [3:0] a;
      logic [7:0] w, n;
      logic       e;
   } vec_t;

   // t=trigger sel, p=keys pressed, q=gate sel, d=debounce, h=gate hold,
   // c=combo hold, a=actions, w=gate lead cycles, n=trigger low cycles, e=expect
   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{4'h3, 4'h3, 4'h0, 8'd2, 8'd0, 8'd5, 4'hF, 8'd0, 8'd10, 1'b1},
      '{4'h3, 4'h3, 4'h0, 8'd2, 8'd0, 8'd5, 4'hF, 8'd0, 8'd7,  1'b0},
      '{4'h3, 4'h3, 4'h0, 8'd2, 8'd0, 8'd5, 4'hF, 8'd0, 8'd8,  1'b1},
      '{4'h3, 4'h1, 4'h0, 8'd2, 8'd0, 8'd5, 4'hF, 8'd0, 8'd12, 1'b0},
      '{4'h7, 4'h7, 4'h8, 8'd2, 8'd4, 8'd3, 4'hF, 8'd9, 8'd8,  1'b1},
      '{4'h7, 4'h7, 4'h8, 8'd2, 8'd4, 8'd3, 4'hF, 8'd6, 8'd8,  1'b0},
      '{4'h7, 4'h7, 4'h8, 8'd2, 8'd4, 8'd3, 4'hF, 8'd7, 8'd8,  1'b1},
      '{4'h5, 4'h5, 4'h0, 8'd3, 8'd0, 8'd2, 4'h2, 8'd0, 8'd8,  1'b1},
      '{4'h1, 4'h1, 4'h0, 8'd0, 8'd0, 8'd0, 4'h9, 8'd0, 8'd3,  1'b1},
      '{4'h1, 4'h1, 4'h0, 8'd0, 8'd0, 8'd0, 4'h9, 8'd0, 8'd2,  1'b0}
   };

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic cycles(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   task automatic clear_status();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int b0, i0, e0, s0;
      // R11 reset state
      cycles(3);
      check("R11 stat in reset", int'(stat), 0);
      check("R11 pulses in reset", int'(bat | irq | ec | sys), 0);
      rst_n = 1'b1;
      cycles(2);
      check("R11 stat after reset", int'(stat), 0);
      en = 1'b1;

      // R1 R3 R5 R7 R8 R9 table walk
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         tsel = TBL[v].t; psel = TBL[v].q; deb = TW'(TBL[v].d);
         ph = TW'(TBL[v].h); ch = TW'(TBL[v].c); act = TBL[v].a; keys = '1;
         cycles(3);
         clear_status();
         b0 = n_bat; i0 = n_irq; e0 = n_ec; s0 = n_sys;
         keys = ~psel;
         cycles(int'(TBL[v].w));
         keys = ~(psel | TBL[v].p);
         cycles(int'(TBL[v].n));
         keys = ~psel;
         cycles(2);
         keys = '1;
         cycles(int'(TBL[v].d) + int'(TBL[v].h) + int'(TBL[v].c) + 6);
         check($sformatf("R8 bat vec%0d", v), n_bat - b0, int'(TBL[v].e & TBL[v].a[0]));
         check($sformatf("R8 irq vec%0d", v), n_irq - i0, int'(TBL[v].e & TBL[v].a[1]));
         check($sformatf("R3 ec vec%0d", v),  n_ec - e0,  int'(TBL[v].e & TBL[v].a[2]));
         check($sformatf("R5 sys vec%0d", v), n_sys - s0, int'(TBL[v].e & TBL[v].a[3]));
         check($sformatf("R9 stat vec%0d", v), int'(stat), int'(TBL[v].e));
      end

      // R2 bounce between the two samples is ignored
      @(negedge clk);
      tsel = 4'h1; psel = 4'h0; deb = 16'd4; ph = 16'd0; ch = 16'd3; act = 4'hF;
      cycles(2); clear_status();
      i0 = n_irq;
      keys = 4'hE; cycles(1);
      keys = 4'hF; cycles(1);
      keys = 4'hE; cycles(10);
      keys = 4'hF; cycles(4);
      check("R2 bounce inside debounce", n_irq - i0, 1);

      // R4 rise in hold aborts, a new edge fires
      @(negedge clk);
      deb = 16'd2; ch = 16'd6;
      i0 = n_irq;
      keys = 4'hE; cycles(6);
      keys = 4'hF; cycles(3);
      check("R4 rise in hold aborts", n_irq - i0, 0);
      keys = 4'hE; cycles(12);
      keys = 4'hF; cycles(3);
      check("R4 new edge fires", n_irq - i0, 1);

      // R6 gate release aborts
      @(negedge clk);
      psel = 4'h8; ph = 16'd2;
      i0 = n_irq;
      keys = 4'h7; cycles(8);
      keys = 4'h6; cycles(4);
      keys = 4'hE; cycles(12);
      keys = 4'hF; cycles(3);
      check("R6 gate release aborts", n_irq - i0, 0);

      // R10 enable drop cancels, re-enable needs a new edge
      @(negedge clk);
      psel = 4'h0;
      i0 = n_irq;
      keys = 4'hE; cycles(4);
      en = 1'b0; cycles(3);
      en = 1'b1; cycles(15);
      check("R10 no fire across disable", n_irq - i0, 0);
      keys = 4'hF; cycles(2);
      clear_status();
      keys = 4'hE; cycles(12);
      keys = 4'hF; cycles(3);
      check("R10 fires after new edge", n_irq - i0, 1);

      // R9 sticky then cleared
      cycles(10);
      check("R9 status sticky", int'(stat), 1);
      clear_status();
      check("R9 status cleared", int'(stat), 0);

      finish_run();
   end
endmodule